// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block sits next to an 8-bit CPU core and decides which of fifteen interrupt sources the core should serve next. Each source passes through its own enable bit and a shared global enable. It is then placed at one of two urgency levels by a per-source priority bit. Among the survivors, the block picks one winner and presents a request together with the 16-bit start address of that source's handler.

The block records which urgency levels are being serviced, so that nesting follows a strict rule. A high-level request may interrupt a low-level handler. Nothing may interrupt a high-level handler. An acknowledge strobe from the core marks the pending level as in service. A return strobe retires the most urgent level that is in service. The pending request and its address are held steady from the moment they are chosen until the core acknowledges them.

Top module: `nestIntCtrl`

## Requirements
- R1: A synchronous active-low reset deasserts `irqReq` and clears both in-service levels. After reset, any eligible request of either level is accepted.
- R2: A source takes part in arbitration only when its `irqLines` bit, its `srcEnable` bit and `globalEnable` are all 1. The bit index is the source number given in R5.
- R3: When eligible requests exist at both levels, the winner is a high-level one. A `srcPriority` bit of 1 means high and 0 means low.
- R4: Among eligible requests of the same level, the winner is the earliest in this order of source numbers: 0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14.
- R5: Source numbers and their vectors are as follows. Numbers 0 to 14 are ext0, tmr0, ext1, tmr1, uart, i2c, tmr2, ext2, ext3, ext4, ext5, ext6, ext7, ext8 and adc. Source n vectors to 8*n+3, giving hex 0003 through 0073.
- R6: Arbitration runs on every cycle with no request outstanding, and its result appears on `irqReq`/`irqVector` one cycle later. While `irqReq` is high and `cpuAck` is low, `irqVector` and the pending level do not change, even when the request lines change.
- R7: `cpuAck` while `irqReq` is high marks the pending level as in service and drops `irqReq` on the next cycle. `cpuAck` while `irqReq` is low has no effect.
- R8: While only the low level is in service, only high-level requests can win.
- R9: While the high level is in service, no request is raised.
- R10: `retStrobe` clears the high in-service level if it is set, and otherwise clears the low one.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| irqLines | input | 15 | Raw request per source, bit n = source n |
| srcEnable | input | 15 | Per-source enable |
| globalEnable | input | 1 | Master enable for all sources |
| srcPriority | input | 15 | Per-source level, 1 = high |
| cpuAck | input | 1 | CPU takes the pending request |
| retStrobe | input | 1 | CPU leaves the current handler |
| irqReq | output | 1 | Request to the CPU |
| irqVector | output | 16 | Handler address of the pending request |

## Verification
The assertions assume that the core raises `cpuAck` only while `irqReq` is high, and raises `retStrobe` only while some level is in service. They also assume the two strobes are not raised in the same cycle. The random stimulus keeps to these rules: acknowledges and returns are drawn only when the bench's own model shows a pending request or an active level, and a return is never drawn in an acknowledge cycle. A directed case deliberately acknowledges with nothing pending to exercise R7. No assertion is left depending on it.

// File: rtl/nestIntPkg.sv
package nestIntPkg;
  localparam int NUM_SRC    = 15;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int VEC_W      = 16;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  // polling order interleaves the sources in three columns of five
  localparam int POLL_COLS  = 3;
  localparam int POLL_GROUP = NUM_SRC / POLL_COLS;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  typedef struct packed {
    logic load;       // arbitration result may be captured
    logic allowHigh;  // high-level requests may compete
    logic allowLow;   // low-level requests may compete
  } ctrlStrobes_t;

  // source number polled at position r of the fixed order
  function automatic int srcAtRank(int r);
    return (r % POLL_COLS) * POLL_GROUP + r / POLL_COLS;
  endfunction

  function automatic logic [VEC_W-1:0] vectorOf(logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx));
  endfunction
endpackage

// File: rtl/intPollPick.sv
module intPollPick
  import nestIntPkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = IDX_W
) (
  input  logic [N-1:0] reqMask,
  output logic         found,
  output logic [W-1:0] winIdx
);
  logic [N-1:0] ordered;

  // place requests in polling order: bit r = request at rank r
  for (genvar r = 0; r < N; r++) begin : g_order
    assign ordered[r] = reqMask[srcAtRank(r)];
  end

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (ordered[r]) begin
        found  = 1'b1;
        winIdx = W'(srcAtRank(r));
      end
    end
  end
endmodule

// File: rtl/intDatapath.sv
module intDatapath
  import nestIntPkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = IDX_W,
  parameter int V = VEC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] irqLines,
  input  logic [N-1:0] srcEnable,
  input  logic         globalEnable,
  input  logic [N-1:0] srcPriority,
  input  ctrlStrobes_t strobes,
  output logic         winValid,
  output level_e       pendLevel,
  output logic [V-1:0] irqVector
);
  logic [N-1:0] eligible, highMask, lowMask;
  logic         highFound, lowFound;
  logic [W-1:0] highIdx, lowIdx, winIdx;
  level_e       winLevel;

  always_comb begin
    eligible = irqLines & srcEnable & {N{globalEnable}};
    highMask = eligible & srcPriority & {N{strobes.allowHigh}};
    lowMask  = eligible & ~srcPriority & {N{strobes.allowLow}};
  end

  intPollPick #(.N(N), .W(W)) i_pickHigh (
    .reqMask(highMask), .found(highFound), .winIdx(highIdx)
  );
  intPollPick #(.N(N), .W(W)) i_pickLow (
    .reqMask(lowMask), .found(lowFound), .winIdx(lowIdx)
  );

  always_comb begin
    winValid = highFound || lowFound;
    winLevel = highFound ? LVL_HIGH : LVL_LOW;
    winIdx   = highFound ? highIdx : lowIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqVector <= '0;
      pendLevel <= LVL_LOW;
    end else if (strobes.load && winValid) begin
      irqVector <= V'(vectorOf(winIdx));
      pendLevel <= winLevel;
    end
  end
endmodule

// File: rtl/intControl.sv
module intControl
  import nestIntPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuAck,
  input  logic         retStrobe,
  input  logic         winValid,
  input  level_e       pendLevel,
  output ctrlStrobes_t strobes,
  output logic         irqReq,
  output logic [1:0]   inSvc
);
  logic       ackTaken, reqNext;
  logic [1:0] svcNext;

  always_comb begin
    strobes.load      = !irqReq;
    strobes.allowHigh = !inSvc[1];
    strobes.allowLow  = !inSvc[1] && !inSvc[0];
  end

  always_comb begin
    ackTaken = irqReq && cpuAck;
    reqNext  = irqReq ? !cpuAck : winValid;
    svcNext  = inSvc;
    if (retStrobe) begin
      if (svcNext[1]) svcNext[1] = 1'b0;
      else            svcNext[0] = 1'b0;
    end
    if (ackTaken) begin
      if (pendLevel == LVL_HIGH) svcNext[1] = 1'b1;
      else                       svcNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      inSvc  <= 2'b00;
    end else begin
      irqReq <= reqNext;
      inSvc  <= svcNext;
    end
  end
endmodule

// File: rtl/nestIntCtrl.sv
module nestIntCtrl
  import nestIntPkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int V = VEC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] irqLines,
  input  logic [N-1:0] srcEnable,
  input  logic         globalEnable,
  input  logic [N-1:0] srcPriority,
  input  logic         cpuAck,
  input  logic         retStrobe,
  output logic         irqReq,
  output logic [V-1:0] irqVector
);
  localparam int W = $clog2(N);

  ctrlStrobes_t strobes;
  logic         winValid;
  level_e       pendLevel;
  logic [1:0]   inSvc;

  intDatapath #(.N(N), .W(W), .V(V)) i_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .srcPriority(srcPriority),
    .strobes(strobes), .winValid(winValid), .pendLevel(pendLevel),
    .irqVector(irqVector)
  );

  intControl i_ctrl (
    .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .retStrobe(retStrobe),
    .winValid(winValid), .pendLevel(pendLevel), .strobes(strobes),
    .irqReq(irqReq), .inSvc(inSvc)
  );
endmodule

// File: rtl/nestIntChecker.sv
module nestIntChecker #(
  parameter int V = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cpuAck,
  input logic         retStrobe,
  input logic         irqReq,
  input logic [V-1:0] irqVector,
  input logic         pendLevel,
  input logic [1:0]   inSvc
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> !irqReq && inSvc == 2'b00);

  assert_vector_form_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqVector[2:0] == 3'b011 && irqVector <= V'(16'h0073));

  assert_hold_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !cpuAck |=> irqReq && $stable(irqVector) && $stable(pendLevel));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && cpuAck |=> !irqReq);

  assert_idle_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq && cpuAck && !retStrobe |=> $stable(inSvc));

  assert_low_nest_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && inSvc == 2'b01 |-> pendLevel);

  assert_high_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    inSvc[1] |-> !irqReq);

  assert_ret_high_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe && !cpuAck && inSvc[1] |=> !inSvc[1] && inSvc[0] == $past(inSvc[0]));
endmodule

bind nestIntCtrl nestIntChecker #(.V(V)) i_chk (
  .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .retStrobe(retStrobe),
  .irqReq(irqReq), .irqVector(irqVector), .pendLevel(pendLevel),
  .inSvc(inSvc)
);

// File: tb/test_nestIntCtrl.sv
`timescale 1ns/1ps
module test_nestIntCtrl;
  localparam int N = 15;
  localparam int POLL[N] = '{0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14};

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  irqLines, srcEnable, srcPriority;
  logic          globalEnable, cpuAck, retStrobe;
  logic          irqReq;
  logic [15:0]   irqVector;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic        mReq;
  logic [15:0] mVec;
  logic        mLvl;
  logic [1:0]  mSvc;

  always #2 clk = ~clk;

  nestIntCtrl i_nestIntCtrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .srcPriority(srcPriority),
    .cpuAck(cpuAck), .retStrobe(retStrobe), .irqReq(irqReq),
    .irqVector(irqVector)
  );

  function automatic int pickFirst(logic [N-1:0] m);
    for (int r = 0; r < N; r++) if (m[POLL[r]]) return POLL[r];
    return -1;
  endfunction

  function automatic logic [15:0] vecOf(int s);
    return 16'(8 * s + 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model advances with the DUT, outputs compared at negedge
  task automatic cyc(string tag);
    logic [N-1:0] elig, hi, lo;
    int w;
    logic        nReq, nLvl;
    logic [15:0] nVec;
    logic [1:0]  nSvc;
    nReq = mReq; nVec = mVec; nLvl = mLvl; nSvc = mSvc;
    if (!rstN) begin
      nReq = 0; nVec = 0; nLvl = 0; nSvc = 0;
    end else begin
      if (retStrobe) begin
        if (nSvc[1]) nSvc[1] = 0; else nSvc[0] = 0;
      end
      if (mReq) begin
        if (cpuAck) begin
          nReq = 0;
          nSvc[mLvl] = 1'b1;
        end
      end else begin
        elig = irqLines & srcEnable & {N{globalEnable}};
        hi = mSvc[1] ? '0 : (elig & srcPriority);
        lo = (mSvc != 0) ? '0 : (elig & ~srcPriority);
        w = pickFirst(hi);
        if (w >= 0) begin
          nReq = 1; nVec = vecOf(w); nLvl = 1;
        end else begin
          w = pickFirst(lo);
          if (w >= 0) begin
            nReq = 1; nVec = vecOf(w); nLvl = 0;
          end
        end
      end
    end
    @(posedge clk);
    mReq = nReq; mVec = nVec; mLvl = nLvl; mSvc = nSvc;
    @(negedge clk);
    chk({tag, " request"}, 32'(irqReq), 32'(mReq));
    if (mReq) chk({tag, " vector"}, 32'(irqVector), 32'(mVec));
  endtask

  task automatic idleIn();
    irqLines = '0; srcEnable = '1; globalEnable = 1; srcPriority = '0;
    cpuAck = 0; retStrobe = 0;
  endtask

  // acknowledge what is pending, then return from it
  task automatic serveAndReturn(string tag);
    cpuAck = 1; cyc(tag); cpuAck = 0;
    retStrobe = 1; cyc(tag); retStrobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mReq = 0; mVec = 0; mLvl = 0; mSvc = 0;
    idleIn();
    rstN = 0;
    @(negedge clk);
    // R1: reset with busy inputs holds request low
    irqLines = '1; cpuAck = 1; retStrobe = 1;
    repeat (3) cyc("R1");
    chk("R1 reset request", 32'(irqReq), 0);
    idleIn(); rstN = 1;
    cyc("R1");

    // R2: gating by per-source and global enables
    irqLines = '1; srcEnable = '0; cyc("R2"); cyc("R2");
    chk("R2 no enables", 32'(irqReq), 0);
    srcEnable = '1; globalEnable = 0; cyc("R2"); cyc("R2");
    chk("R2 global off", 32'(irqReq), 0);
    globalEnable = 1; srcEnable = 15'(1 << 9); irqLines = 15'(1 << 9); cyc("R2");
    chk("R2 single enabled", 32'(irqVector), 32'h004B);
    serveAndReturn("R2"); idleIn(); cyc("R2");

    // R5: each source alone, vector table
    for (int s = 0; s < N; s++) begin
      irqLines = 15'(1 << s); srcPriority = 15'(s[0] << s); cyc("R5");
      chk("R5 vector", 32'(irqVector), 32'(8 * s + 3));
      serveAndReturn("R5"); idleIn(); cyc("R5");
    end

    // R4: all low-level lines set, served one by one in polling order
    irqLines = '1;
    for (int r = 0; r < N; r++) begin
      cyc("R4");
      chk("R4 poll order", 32'(irqVector), 32'(8 * POLL[r] + 3));
      cpuAck = 1; cyc("R4"); cpuAck = 0;
      irqLines[POLL[r]] = 1'b0;
      retStrobe = 1; cyc("R4"); retStrobe = 0;
    end
    idleIn(); cyc("R4");

    // R3: a later-polled high source beats an earlier low source
    irqLines = 15'(1) | 15'(1 << 14); srcPriority = 15'(1 << 14); cyc("R3");
    chk("R3 high wins", 32'(irqVector), 32'h0073);
    serveAndReturn("R3"); idleIn(); cyc("R3");

    // R8: low in service blocks low, admits high
    irqLines = 15'(1 << 3); cyc("R8");
    cpuAck = 1; cyc("R8"); cpuAck = 0;
    irqLines = 15'(1 << 0); cyc("R8"); cyc("R8");
    chk("R8 low blocked", 32'(irqReq), 0);
    irqLines = 15'(1 << 0) | 15'(1 << 6); srcPriority = 15'(1 << 6); cyc("R8");
    chk("R8 high admitted", 32'(irqVector), 32'h0033);

    // R9: high in service blocks everything
    cpuAck = 1; cyc("R9"); cpuAck = 0;
    irqLines = '1; srcPriority = 15'h5555; cyc("R9"); cyc("R9");
    chk("R9 nothing under high", 32'(irqReq), 0);

    // R10: return clears high first, low still in service
    irqLines = 15'(1 << 1); srcPriority = 15'(1 << 2);
    retStrobe = 1; cyc("R10"); retStrobe = 0;
    cyc("R10"); cyc("R10");
    chk("R10 low still active", 32'(irqReq), 0);
    irqLines = 15'(1 << 1) | 15'(1 << 2); cyc("R10");
    chk("R10 high allowed", 32'(irqVector), 32'h0013);
    cpuAck = 1; cyc("R10"); cpuAck = 0;
    irqLines = '0;
    retStrobe = 1; cyc("R10"); cyc("R10"); retStrobe = 0;
    irqLines = 15'(1 << 1); srcPriority = '0; cyc("R10");
    chk("R10 all retired", 32'(irqVector), 32'h000B);
    serveAndReturn("R10"); idleIn(); cyc("R10");

    // R7: acknowledge with nothing pending changes nothing
    cpuAck = 1; cyc("R7"); cpuAck = 0;
    irqLines = 15'(1 << 12); cyc("R7");
    chk("R7 idle ack ignored", 32'(irqVector), 32'h0063);

    // R6: pending request is held while a higher source appears
    irqLines = 15'(1 << 12) | 15'(1 << 0); srcPriority = 15'(1 << 0);
    cyc("R6"); cyc("R6");
    chk("R6 vector held", 32'(irqVector), 32'h0063);
    irqLines = '0; cyc("R6");
    chk("R6 held after line drop", 32'(irqReq), 1);
    serveAndReturn("R6"); idleIn(); cyc("R6");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      irqLines     = 15'($urandom() & $urandom());
      srcEnable    = 15'(~($urandom() & $urandom() & $urandom()));
      globalEnable = ($urandom() % 8) != 0;
      srcPriority  = 15'($urandom() & $urandom());
      cpuAck       = mReq && ($urandom() % 3 == 0);
      retStrobe    = !cpuAck && (mSvc != 0) && ($urandom() % 4 == 0);
      rstN         = ($urandom() % 500) != 0;
      cyc(rstN ? "R6 random" : "R1 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule